// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-driven master for the two-wire PHY management bus. It runs standard read and write frames to external PHYs. A host reaches it through a small 32-bit register port with six word registers: a configuration word, a read command bit, a target address, outgoing write data, captured read data and a status word. The block drives the management clock and the data line. The data line has a separate output enable so that a pad or an external tri-state buffer can release it while the PHY answers a read.

Writing the outgoing-data register starts a write frame as a side effect. A read starts only when the command bit goes from 0 to 1, so software first clears the bit and then sets it. The status word shows whether a frame is in flight and whether the captured read data is still stale. A reset bit in the configuration word stops any frame at once and returns the engine to idle. The low bits of the same word set the management clock rate as a fraction of the host clock.

Top module: `mdio_master`

## Requirements
- R1: After reset every register reads 0, the management clock is low and the data output enable is 0.
- R2: Register words sit at byte offsets 0x00 configuration, 0x04 command, 0x08 address, 0x0C write data, 0x10 read data and 0x14 status. Configuration reads back only bits 2:0 (divider select). The address word holds the PHY number in bits 12:8 and the register number in bits 4:0. Write data reads back in bits 15:0.
- R3: While a frame runs, the management clock period is 8 x (divider select + 1) host clocks with equal high and low halves. Between frames the clock is held low.
- R4: A write to 0x0C starts a 64-bit write frame. Every bit of it is driven, MSB first, and changes only after a falling clock edge. The frame is 32 ones, then 01, then opcode 01, then the 5-bit PHY number, the 5-bit register number, turnaround 10 and the 16 data bits.
- R5: A 0-to-1 change of command bit 0 starts a read frame with opcode 10. The output enable drops for the two turnaround bits and the 16 data bits. Data is sampled on rising clock edges, MSB first, and lands in bits 15:0 of the read data word.
- R6: Status bit 0 (busy) is 1 from the cycle after the starting write until the last falling clock edge of the frame: 64 x 8 x (select + 1) cycles in total.
- R7: Status bit 2 (data stale) is set when a read starts. It clears in the same cycle that the read data word is updated.
- R8: Writing 1 to the command bit while it already holds 1 starts no frame.
- R9: While busy is 1, writes to the address, write-data and command registers are ignored and start no frame.
- R10: Writing configuration with bit 31 set aborts any frame. In the next cycle busy and data stale are 0, the clock is low, the output enable is 0 and the command bit is 0. The read data word keeps its old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | Data line as seen at the pad |
| mdio_o | output | 1 | Data line drive value |
| mdio_oe | output | 1 | Data line drive enable |

## Verification
Some properties are checked by assertions on every cycle. The clock stays low whenever no frame runs. A write to the data register while idle always raises busy. Address writes during a frame leave the address unchanged. A repeated command write starts nothing. An abort clears busy, the stale flag and the output enable. The stale flag falls only on a frame completion or an abort. The preamble drives ones.

Other behaviour can only be shown by the bench scenarios. These are the exact bit order of whole frames, the clock period at each divider select, the exact busy length, and the read data as the PHY answers. The bench also shows that the address, data and command registers keep their values after writes made in the middle of a frame, and that a read can be started again after an abort.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
    localparam int unsigned REG_W      = 32;
    localparam int unsigned REG_AW     = 5;
    localparam int unsigned DIV_SEL_W  = 3;
    localparam int unsigned PHY_AW     = 5;
    localparam int unsigned WORD_W     = 16;
    localparam int unsigned PREAMBLE_N = 32;

    // word index of each register (byte address bits 4:2)
    localparam logic [2:0] RG_CFG = 3'd0;
    localparam logic [2:0] RG_CMD = 3'd1;
    localparam logic [2:0] RG_ADR = 3'd2;
    localparam logic [2:0] RG_CTL = 3'd3;
    localparam logic [2:0] RG_STA = 3'd4;
    localparam logic [2:0] RG_IND = 3'd5;

    // frame field codes
    localparam logic [1:0] FR_START = 2'b01;
    localparam logic [1:0] FR_OP_RD = 2'b10;
    localparam logic [1:0] FR_OP_WR = 2'b01;
    localparam logic [1:0] FR_TA_WR = 2'b10;

    localparam int unsigned ABORT_BIT = 31;
endpackage

// File: rtl/mdio_clkgen.sv
`timescale 1ns/1ps
module mdio_clkgen #(
    parameter int unsigned DIV_W = mdio_pkg::DIV_SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_sel,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);
    localparam int unsigned CNT_W = DIV_W + 3;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             mdc;
    } clk_state_t;

    clk_state_t q, d;
    logic [CNT_W-1:0] half_m1;
    logic             wrap;

    always_comb begin
        // half period = 4 * (sel + 1) host clocks
        half_m1 = {1'b0, div_sel, 2'b11};
        wrap    = run && (q.cnt >= half_m1);
        d       = q;
        if (!run) begin
            d.cnt = '0;
            d.mdc = 1'b0;
        end else if (wrap) begin
            d.cnt = '0;
            d.mdc = !q.mdc;
        end else begin
            d.cnt = q.cnt + CNT_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mdc  = q.mdc;
    assign rise = wrap && !q.mdc;
    assign fall = wrap && q.mdc;

    // R3: the counter never runs past the half period while the select holds
    a_r3_half_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $stable(div_sel)) |-> (q.cnt <= half_m1));
endmodule

// File: rtl/mdio_shifter.sv
`timescale 1ns/1ps
module mdio_shifter #(
    parameter int unsigned PHY_W    = mdio_pkg::PHY_AW,
    parameter int unsigned DATA_W   = mdio_pkg::WORD_W,
    parameter int unsigned PRE_BITS = mdio_pkg::PREAMBLE_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_read,
    input  logic [PHY_W-1:0]  phy,
    input  logic [PHY_W-1:0]  regn,
    input  logic [DATA_W-1:0] wdata,
    input  logic              abort,
    input  logic              rise,
    input  logic              fall,
    input  logic              mdio_i,
    output logic              active,
    output logic              done,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [DATA_W-1:0] rdata
);
    import mdio_pkg::*;

    localparam int unsigned FRAME_BITS = PRE_BITS + 6 + 2*PHY_W + DATA_W;
    localparam int unsigned IDX_W      = $clog2(FRAME_BITS + 1);
    localparam int unsigned TA_IDX     = PRE_BITS + 4 + 2*PHY_W;
    localparam int unsigned DATA_IDX   = TA_IDX + 2;
    localparam logic [IDX_W-1:0] IDX_ONE  = IDX_W'(1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BITS - 1);
    localparam logic [IDX_W-1:0] IDX_TA   = IDX_W'(TA_IDX);
    localparam logic [IDX_W-1:0] IDX_DAT  = IDX_W'(DATA_IDX);
    localparam logic [IDX_W-1:0] IDX_PRE  = IDX_W'(PRE_BITS);

    typedef struct packed {
        logic                  active;
        logic                  rd;
        logic [IDX_W-1:0]      idx;
        logic [FRAME_BITS-1:0] sh;
        logic [DATA_W-1:0]     rx;
    } shift_state_t;

    shift_state_t q, d;

    always_comb begin
        d    = q;
        done = 1'b0;
        if (abort) begin
            d.active = 1'b0;
            d.idx    = '0;
        end else if (start && !q.active) begin
            d.active = 1'b1;
            d.rd     = is_read;
            d.idx    = '0;
            d.rx     = '0;
            d.sh     = {{PRE_BITS{1'b1}}, FR_START,
                        is_read ? FR_OP_RD : FR_OP_WR, phy, regn,
                        is_read ? 2'b00 : FR_TA_WR,
                        is_read ? {DATA_W{1'b0}} : wdata};
        end else if (q.active) begin
            if (rise && q.rd && (q.idx >= IDX_DAT))
                d.rx = {q.rx[DATA_W-2:0], mdio_i};
            if (fall) begin
                d.sh = {q.sh[FRAME_BITS-2:0], 1'b0};
                if (q.idx == IDX_LAST) begin
                    d.active = 1'b0;
                    d.idx    = '0;
                    done     = 1'b1;
                end else begin
                    d.idx = q.idx + IDX_ONE;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign active  = q.active;
    assign mdio_o  = q.active && q.sh[FRAME_BITS-1];
    assign mdio_oe = q.active && (!q.rd || (q.idx < IDX_TA));
    assign rdata   = q.rx;

    // R4: every preamble bit on the line is a one
    a_r4_preamble_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (q.active && (q.idx < IDX_PRE)) |-> (mdio_oe && mdio_o));
    // R5: a read frame never drives the line in its data field
    a_r5_read_released: assert property (@(posedge clk) disable iff (!rst_n)
        (q.active && q.rd && (q.idx >= IDX_DAT)) |-> !mdio_oe);
endmodule

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
module mdio_master #(
    parameter int unsigned DIV_W    = mdio_pkg::DIV_SEL_W,
    parameter int unsigned PHY_W    = mdio_pkg::PHY_AW,
    parameter int unsigned DATA_W   = mdio_pkg::WORD_W,
    parameter int unsigned PRE_BITS = mdio_pkg::PREAMBLE_N
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [4:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    input  logic        mdio_i,
    output logic        mdio_o,
    output logic        mdio_oe
);
    import mdio_pkg::*;

    localparam int unsigned PHY_LSB = 8;

    typedef struct packed {
        logic [DIV_W-1:0]  sel;
        logic              cmd;
        logic [PHY_W-1:0]  phy;
        logic [PHY_W-1:0]  regn;
        logic [DATA_W-1:0] ctl;
        logic [DATA_W-1:0] stat;
        logic              nv;
    } regs_t;

    regs_t q, d;
    logic [2:0]        wsel;
    logic              busy, sh_done, start, start_rd, abort;
    logic              tick_rise, tick_fall;
    logic [DATA_W-1:0] rx_word;
    logic              unused_bits;

    assign wsel        = reg_addr[REG_AW-1:2];
    assign unused_bits = ^{reg_wdata[REG_W-2:DATA_W], reg_addr[1:0]};

    always_comb begin
        d        = q;
        start    = 1'b0;
        start_rd = 1'b0;
        abort    = 1'b0;
        if (sh_done && q.nv) begin
            d.stat = rx_word;
            d.nv   = 1'b0;
        end
        if (reg_wr) begin
            case (wsel)
                RG_CFG: begin
                    d.sel = reg_wdata[DIV_W-1:0];
                    if (reg_wdata[ABORT_BIT]) begin
                        abort = 1'b1;
                        d.cmd = 1'b0;
                        d.nv  = 1'b0;
                    end
                end
                RG_CMD: if (!busy) begin
                    d.cmd = reg_wdata[0];
                    if (reg_wdata[0] && !q.cmd) begin
                        start    = 1'b1;
                        start_rd = 1'b1;
                        d.nv     = 1'b1;
                    end
                end
                RG_ADR: if (!busy) begin
                    d.phy  = reg_wdata[PHY_LSB +: PHY_W];
                    d.regn = reg_wdata[0 +: PHY_W];
                end
                RG_CTL: if (!busy) begin
                    d.ctl = reg_wdata[DATA_W-1:0];
                    start = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        reg_rdata = '0;
        case (wsel)
            RG_CFG: reg_rdata[DIV_W-1:0] = q.sel;
            RG_CMD: reg_rdata[0] = q.cmd;
            RG_ADR: begin
                reg_rdata[PHY_LSB +: PHY_W] = q.phy;
                reg_rdata[0 +: PHY_W]       = q.regn;
            end
            RG_CTL: reg_rdata[DATA_W-1:0] = q.ctl;
            RG_STA: reg_rdata[DATA_W-1:0] = q.stat;
            RG_IND: begin
                reg_rdata[0] = busy;
                reg_rdata[2] = q.nv;
            end
            default: ;
        endcase
    end

    mdio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy && !abort),
        .div_sel (q.sel),
        .mdc     (mdc),
        .rise    (tick_rise),
        .fall    (tick_fall)
    );

    mdio_shifter #(.PHY_W(PHY_W), .DATA_W(DATA_W), .PRE_BITS(PRE_BITS)) u_shifter (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .is_read (start_rd),
        .phy     (q.phy),
        .regn    (q.regn),
        .wdata   (reg_wdata[DATA_W-1:0]),
        .abort   (abort),
        .rise    (tick_rise),
        .fall    (tick_fall),
        .mdio_i  (mdio_i),
        .active  (busy),
        .done    (sh_done),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .rdata   (rx_word)
    );

    // R3: clock held low outside frames
    a_r3_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);
    // R6: an idle write to the data register raises busy
    a_r6_ctl_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (wsel == RG_CTL) && !busy) |=> busy);
    // R7: stale flag falls only on completion or abort
    a_r7_nv_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.nv) |-> ($past(sh_done) || $past(reg_wr && (wsel == RG_CFG) && reg_wdata[ABORT_BIT])));
    // R8: repeated command write while already set starts nothing
    a_r8_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (wsel == RG_CMD) && q.cmd && !busy) |=> !busy);
    // R9: address locked during a frame
    a_r9_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (wsel == RG_ADR) && busy) |=> ($stable(q.phy) && $stable(q.regn)));
    // R10: abort clears the engine in one cycle
    a_r10_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (wsel == RG_CFG) && reg_wdata[ABORT_BIT]) |=> (!busy && !q.nv && !mdio_oe && !mdc));
endmodule

// File: tb/mdio_master_test.sv
`timescale 1ns/1ps
module mdio_master_test;
    localparam logic [4:0] A_CFG = 5'h00;
    localparam logic [4:0] A_CMD = 5'h04;
    localparam logic [4:0] A_ADR = 5'h08;
    localparam logic [4:0] A_CTL = 5'h0C;
    localparam logic [4:0] A_STA = 5'h10;
    localparam logic [4:0] A_IND = 5'h14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = A_IND;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        mdc;
    logic        mdio_i = 1'b1;
    logic        mdio_o;
    logic        mdio_oe;

    int          n_chk = 0;
    int          n_bad = 0;
    int          rc = 0;
    int          busy_cnt = 0;
    int          cyc = 0;
    time         t_r0 = 0;
    time         t_r1 = 0;
    logic        cap_o  [0:63];
    logic        cap_oe [0:63];
    logic [15:0] phy_val = 16'h0;

    mdio_master uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mdc       (mdc),
        .mdio_i    (mdio_i),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe)
    );

    always #2 clk = ~clk;

    // PHY model: record the line at each rising clock edge
    always @(posedge mdc) begin
        if (rc < 64) begin
            cap_o[rc]  = mdio_o;
            cap_oe[rc] = mdio_oe;
        end
        if (rc == 0) t_r0 = $time;
        if (rc == 1) t_r1 = $time;
        rc = rc + 1;
    end

    // PHY model: present read data after the falling edge
    always @(negedge mdc) begin
        if (rc >= 48 && rc < 64) mdio_i = phy_val[63 - rc];
        else                     mdio_i = 1'b1;
    end

    always @(posedge clk) begin
        #1;
        if (reg_addr == A_IND && reg_rdata[0] === 1'b1) busy_cnt = busy_cnt + 1;
    end

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 150000) begin
            n_chk = n_chk + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] dv);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = dv;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = A_IND;
    endtask

    task automatic rd(logic [4:0] a, output logic [31:0] dv);
        @(negedge clk);
        reg_addr = a;
        #1;
        dv = reg_rdata;
        reg_addr = A_IND;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (reg_rdata[0] === 1'b1);
    endtask

    task automatic chk_frame(string tag, bit is_rd, logic [4:0] p, logic [4:0] r, logic [15:0] dv);
        logic [63:0] f;
        int errs;
        errs = 0;
        f = {32'hFFFF_FFFF, 2'b01, is_rd ? 2'b10 : 2'b01, p, r,
             is_rd ? 2'b00 : 2'b10, is_rd ? 16'h0 : dv};
        for (int k = 0; k < 64; k++) begin
            logic eoe;
            eoe = !is_rd || (k < 46);
            if (cap_oe[k] !== eoe) errs = errs + 1;
            else if (eoe && (cap_o[k] !== f[63 - k])) errs = errs + 1;
        end
        chk(tag, 32'(errs), 32'd0);
        chk({tag, " rise count"}, 32'(rc), 32'd64);
    endtask

    task automatic run_write(logic [2:0] sel, logic [4:0] p, logic [4:0] r, logic [15:0] dv);
        logic [31:0] v;
        int n;
        wr(A_CFG, {29'h0, sel});
        wr(A_ADR, {19'h0, p, 3'b000, r});
        rc = 0; busy_cnt = 0;
        wr(A_CTL, {16'h0, dv});
        #1 chk("R6 busy right after data write", {31'h0, reg_rdata[0]}, 32'd1);
        wait_idle();
        n = 512 * (int'(sel) + 1);
        // the first busy cycle still shows the data address on the bus
        chk("R6 busy length", 32'(busy_cnt), 32'(n - 1));
        chk_frame("R4 write frame bits", 1'b0, p, r, dv);
        chk("R3 mdc period in clocks", 32'((t_r1 - t_r0) / 4), 32'(8 * (int'(sel) + 1)));
        chk("R3 mdc idle low", {31'h0, mdc}, 32'd0);
        rd(A_CTL, v);
        chk("R2 write data readback", v, {16'h0, dv});
    endtask

    task automatic run_read(logic [2:0] sel, logic [4:0] p, logic [4:0] r, logic [15:0] dv);
        logic [31:0] v;
        int n;
        wr(A_CFG, {29'h0, sel});
        wr(A_ADR, {19'h0, p, 3'b000, r});
        wr(A_CMD, 32'h0);
        phy_val = dv;
        rc = 0; busy_cnt = 0;
        wr(A_CMD, 32'h1);
        #1 chk("R7 busy and stale after read start", reg_rdata, 32'h5);
        wait_idle();
        n = 512 * (int'(sel) + 1);
        chk("R6 read busy length", 32'(busy_cnt), 32'(n - 1));
        chk_frame("R5 read frame bits", 1'b1, p, r, dv);
        rd(A_STA, v);
        chk("R5 read data captured", v, {16'h0, dv});
        rd(A_IND, v);
        chk("R7 stale cleared after capture", v, 32'h0);
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_CFG, v); chk("R1 config after reset", v, 32'h0);
        rd(A_CMD, v); chk("R1 command after reset", v, 32'h0);
        rd(A_ADR, v); chk("R1 address after reset", v, 32'h0);
        rd(A_CTL, v); chk("R1 write data after reset", v, 32'h0);
        rd(A_STA, v); chk("R1 read data after reset", v, 32'h0);
        rd(A_IND, v); chk("R1 status after reset", v, 32'h0);
        chk("R1 mdc low", {31'h0, mdc}, 32'd0);
        chk("R1 oe low", {31'h0, mdio_oe}, 32'd0);

        // R2 field placement
        wr(A_CFG, 32'h0000_0005); rd(A_CFG, v); chk("R2 divider field", v, 32'h5);
        wr(A_CFG, 32'h7FFF_FFFA); rd(A_CFG, v); chk("R2 config reads only 2:0", v, 32'h2);
        wr(A_ADR, 32'hFFFF_FFFF); rd(A_ADR, v); chk("R2 address fields", v, 32'h0000_1F1F);
        rd(A_IND, v); chk("R2 address write starts nothing", v, 32'h0);

        // R3 R4 R6 sweep over every divider select
        for (int s = 0; s < 8; s++) begin
            run_write(3'(s), 5'(s * 3 + 1), 5'(31 - s * 4), 16'hA5C3 ^ 16'(s * 16'h1111));
        end
        run_write(3'd0, 5'd0, 5'd0, 16'h0000);
        run_write(3'd0, 5'd31, 5'd31, 16'hFFFF);

        // R5 R7 reads
        run_read(3'd0, 5'd1, 5'd2, 16'hBEEF);
        run_read(3'd2, 5'd31, 5'd0, 16'h8001);
        run_read(3'd0, 5'd0, 5'd31, 16'h0001);
        run_read(3'd1, 5'd17, 5'd9, 16'h7FFE);

        // R8 command already 1: rewrite 1 does nothing
        rc = 0;
        wr(A_CMD, 32'h1);
        repeat (40) @(negedge clk);
        chk("R8 no frame on repeated set", 32'(rc), 32'd0);
        rd(A_IND, v); chk("R8 idle after repeated set", v, 32'h0);

        // R9 writes during a frame are dropped
        wr(A_CFG, 32'h0);
        wr(A_ADR, 32'h0000_0304);
        rc = 0;
        wr(A_CTL, 32'h0000_1234);
        repeat (20) @(negedge clk);
        wr(A_ADR, 32'h0000_1E1E);
        wr(A_CTL, 32'h0000_FFFF);
        wr(A_CMD, 32'h0);
        wait_idle();
        chk_frame("R9 frame unaffected", 1'b0, 5'd3, 5'd4, 16'h1234);
        rd(A_ADR, v); chk("R9 address kept", v, 32'h0000_0304);
        rd(A_CTL, v); chk("R9 write data kept", v, 32'h0000_1234);
        rd(A_CMD, v); chk("R9 command kept", v, 32'h1);
        repeat (40) @(negedge clk);
        chk("R9 no second frame", 32'(rc), 32'd64);

        // R10 abort in the middle of a read
        wr(A_CMD, 32'h0);
        phy_val = 16'h5A5A;
        rc = 0;
        wr(A_CMD, 32'h1);
        while (rc < 10) @(negedge clk);
        wr(A_CFG, 32'h8000_0000);
        #1;
        chk("R10 status cleared", reg_rdata, 32'h0);
        chk("R10 mdc low", {31'h0, mdc}, 32'd0);
        chk("R10 oe released", {31'h0, mdio_oe}, 32'd0);
        rd(A_CMD, v); chk("R10 command cleared", v, 32'h0);
        rd(A_CFG, v); chk("R10 config reads select only", v, 32'h0);
        rd(A_STA, v); chk("R10 read data kept", v, 32'h0000_7FFE);
        repeat (40) @(negedge clk);
        chk("R10 no more clock edges", 32'(rc), 32'd10);
        run_read(3'd0, 5'd5, 5'd6, 16'hC3A5);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule